// File: doc/BRIEF.md
# Packet Payload Whitening Unit

This block makes the bits of a packet look random on the air and restores them at the far end. A 9-bit linear feedback shift register produces a pseudo-random key stream. Each qualifying serial bit is XORed with the next key bit. The qualifying bits are the payload and the 16-bit CRC that trails it. Bits outside that window pass through untouched, and so do preamble, sync word and header. XOR with an identical stream undoes itself, so one instance serves as scrambler on transmit and as descrambler on receive.

The framing logic marks each packet with a one-cycle frame-start pulse. While payload or CRC bits are on the serial input, it holds a region flag high. A single enable input switches the XOR on or off. The key register restarts from the same seed on every frame start, so both ends of the link produce the same stream. The output bit and its valid strobe come from registers and trail the input by one clock.

Top module: `pkt_whitener`

## Requirements
- R1: The key register is 9 bits wide, s[8:0]. The key bit is s[0]. On each advance the register shifts right, and s[0] XOR s[5] enters at s[8]. Starting from the seed and fed with all-zero payload bits, the first 16 output bits are 1,1,1,1,1,1,1,1,1,0,0,0,0,1,1,1 (hex 0xFF87 read first bit as MSB).
- R2: A frame-start pulse loads the seed 0x1FF. A region bit arriving in the same cycle as the pulse is already combined with the seed's key bit, which is 1.
- R3: The key register advances only in cycles where bit-valid and region are both high. A cycle in the region with valid low neither consumes nor changes the key.
- R4: With the region flag low, the output equals the input and the key register keeps its state, so the stream continues unbroken in the next region bits.
- R5: With enable low, region bits pass through unchanged, but the key register still advances on qualifying cycles. Re-enabling later in the frame resumes the stream at the matching position.
- R6: bit_o and bit_vld_o are registered and show the result for the inputs of the previous clock cycle. bit_vld_o repeats bit_vld_i one cycle later.
- R7: While reset is asserted, bit_o and bit_vld_o are 0 and the key register holds the seed. Region bits sent after reset without a frame-start pulse use the stream from its first bit.
- R8: Whitened bits fed back through the block, framed the same way, come out equal to the original bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Whitening enable, 1 = XOR applied |
| sof_i | input | 1 | Frame-start pulse, reloads the seed |
| bit_vld_i | input | 1 | Serial input bit valid |
| bit_i | input | 1 | Serial input bit |
| region_i | input | 1 | High while payload or CRC bits are on the input |
| bit_o | output | 1 | Serial output bit |
| bit_vld_o | output | 1 | Output bit valid |

## Verification
Every result is due exactly one clock after its inputs: the output register captures at the rising edge, and the bench reads it at the following falling edge. The bench drives each vector at a falling edge and updates its own model of the key stream in the same step. The output it reads back is therefore always paired with the inputs of the cycle before. The reset checks are the only exception. They read the outputs while reset is held, with no edge in between.

// File: rtl/whiten_pkg.sv
package whiten_pkg;
  localparam int unsigned LFSR_W = 9;
  localparam int unsigned TAP    = 5;
  localparam logic [LFSR_W-1:0] SEED = 9'h1FF;
endpackage

// File: rtl/whiten_lfsr.sv
module whiten_lfsr #(
  parameter int unsigned W    = whiten_pkg::LFSR_W,
  parameter int unsigned TAP  = whiten_pkg::TAP,
  parameter logic [W-1:0] SEED = whiten_pkg::SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic         key_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q, eff, nxt;

  // a load is visible in the same cycle, so the first bit uses the seed
  assign eff   = load_i ? SEED : q;
  assign key_o = eff[0];
  assign nxt   = step_i ? {eff[0] ^ eff[TAP], eff[W-1:1]} : eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= nxt;
  end

  assign state_o = q;
endmodule

// File: rtl/whiten_mix.sv
module whiten_mix (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic apply_i,
  input  logic key_i,
  input  logic bit_i,
  input  logic vld_i,
  output logic bit_o,
  output logic vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      bit_o <= bit_i ^ (apply_i & key_i);
      vld_o <= vld_i;
    end
  end
endmodule

// File: rtl/pkt_whitener.sv
module pkt_whitener #(
  parameter int unsigned LFSR_W = whiten_pkg::LFSR_W,
  parameter int unsigned TAP    = whiten_pkg::TAP,
  parameter logic [LFSR_W-1:0] SEED = whiten_pkg::SEED
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sof_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic region_i,
  output logic bit_o,
  output logic bit_vld_o
);
  logic              key;
  logic              adv;
  logic              apply;
  logic [LFSR_W-1:0] lfsr_q;

  assign adv   = bit_vld_i & region_i;
  assign apply = en_i & region_i;

  whiten_lfsr #(.W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sof_i),
    .step_i (adv),
    .key_o  (key),
    .state_o(lfsr_q)
  );

  whiten_mix u_mix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .apply_i(apply),
    .key_i  (key),
    .bit_i  (bit_i),
    .vld_i  (bit_vld_i),
    .bit_o  (bit_o),
    .vld_o  (bit_vld_o)
  );
endmodule

// File: rtl/whiten_chk.sv
module whiten_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sof_i,
  input logic bit_vld_i,
  input logic bit_i,
  input logic region_i,
  input logic bit_o,
  input logic bit_vld_o,
  input logic [whiten_pkg::LFSR_W-1:0] lfsr_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_VLD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> bit_vld_o == $past(bit_vld_i)); // R6
  AST_OUTSIDE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(!region_i)) |-> bit_o == $past(bit_i)); // R4
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(!en_i)) |-> bit_o == $past(bit_i)); // R5
  AST_SOF_SEED_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(sof_i && region_i && en_i)) |-> bit_o != $past(bit_i)); // R2
  AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(!sof_i && !(bit_vld_i && region_i))) |-> $stable(lfsr_q)); // R3
  AST_SOF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(sof_i && !(bit_vld_i && region_i))) |-> lfsr_q == whiten_pkg::SEED); // R2
endmodule

bind pkt_whitener whiten_chk u_chk (.*);

// File: tb/pkt_whitener_tb.sv
module pkt_whitener_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sof = 1'b0, vld = 1'b0, din = 1'b0, rgn = 1'b0;
  logic dout, dvld;
  int total = 0, bad = 0;
  logic [8:0] m_s = 9'h1FF;
  logic exp_b, exp_v;

  always #4 clk = ~clk;

  pkt_whitener u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sof_i(sof),
    .bit_vld_i(vld), .bit_i(din), .region_i(rgn),
    .bit_o(dout), .bit_vld_o(dvld)
  );

  // fields: sof, vld, region, en, bit
  localparam logic [4:0] VEC [24] = '{
    5'b01011, 5'b01010, 5'b01011,          // header, outside region
    5'b11111, 5'b01110, 5'b01111, 5'b01111, // payload starts with sof
    5'b00111, 5'b00110,                    // gap in region, valid low
    5'b01110, 5'b01101, 5'b01100, 5'b01101, // enable off in region
    5'b01111, 5'b01110, 5'b01011, 5'b01111,
    5'b01110, 5'b01111, 5'b01111, 5'b01110,
    5'b01111, 5'b01010, 5'b00000
  };

  function automatic logic [8:0] nstep(input logic [8:0] s);
    return {s[0] ^ s[5], s[8:1]};
  endfunction

  task automatic check(input string req, input logic got, input logic expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", req, got, expv);
    end
  endtask

  // drive at negedge, result appears after the posedge, read at next negedge
  task automatic cyc(input logic s, input logic v, input logic r,
                     input logic e, input logic b, input string req,
                     output logic got);
    logic [8:0] eff;
    sof = s; vld = v; rgn = r; en = e; din = b;
    eff   = s ? 9'h1FF : m_s;
    exp_b = b ^ (e & r & eff[0]);
    exp_v = v;
    m_s   = (v & r) ? nstep(eff) : eff;
    @(posedge clk);
    @(negedge clk);
    got = dout;
    check(req, dout, exp_b);
    check("R6", dvld, exp_v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic g;
    logic [15:0] ks;
    logic [11:0] orig, wht;
    repeat (3) @(negedge clk);
    check("R7", dout, 1'b0);
    check("R7", dvld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: header, sof, gaps, enable toggles (R3 R4 R5)
    for (int i = 0; i < 24; i++)
      cyc(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], "R3/R4/R5", g);

    // R1: fixed key stream from seed with zero payload
    for (int i = 0; i < 16; i++) begin
      cyc(i == 0, 1'b1, 1'b1, 1'b1, 1'b0, "R1", g);
      ks[15-i] = g;
    end
    check("R1", ks == 16'hFF87, 1'b1);

    // R2: sof alone, no data, then stream restarts from seed
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2", g);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2", g);
    check("R2", g, 1'b1);

    // R8: whiten 12 bits then feed them back in a fresh frame
    orig = 12'hA5C;
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4", g);
    for (int i = 0; i < 12; i++) begin
      cyc(i == 0, 1'b1, 1'b1, 1'b1, orig[i], "R8", g);
      wht[i] = g;
    end
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4", g);
    for (int i = 0; i < 12; i++) begin
      cyc(i == 0, 1'b1, 1'b1, 1'b1, wht[i], "R8", g);
      check("R8", g, orig[i]);
    end

    // R7: reset mid-frame restores the seed without sof
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
    sof = 1'b0; vld = 1'b0; rgn = 1'b0; din = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R7", dout, 1'b0);
    check("R7", dvld, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_s = 9'h1FF;
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", g);
      ks[15-i] = g;
    end
    check("R7", ks == 16'hFF87, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule